// File: doc/BRIEF.md
# Stuck-at Fault Injection Miter

This block measures how well a set of input vectors finds single stuck-at defects in a small combinational function, y = (a AND b) OR c. It holds two copies of that function. The reference copy always runs without a fault. The second copy can have one of its five nets pinned to a constant: the three inputs, the internal AND node and the output. A mismatch between the two outputs raises a detect flag.

The block works in two ways. When it is idle, a fault code register and a probe vector input drive both copies directly, so a single fault/vector pair can be examined one at a time. When a sweep is started, a sequencer takes over. It walks every fault in turn, applies every stored vector to each one, and records in a bitmap which faults were caught. A coverage count gives the number of faults caught. Vectors are loaded beforehand through a small write port, together with a count of how many are valid.

Top module: `fault_miter`

## Requirements
- R1: Fault code = 2*net + stuck value, with nets a=0, b=1, c=2, AND node=3, output=4; codes 10 to 15 select no fault, and then bad_out equals good_out for every vector.
- R2: Vectors are 3 bits with a in bit 2, b in bit 1 and c in bit 0; good_out = (a AND b) OR c.
- R3: When idle, detect equals good_out XOR bad_out for the registered fault code and probe_vec, with no clock delay from probe_vec.
- R4: Under a fault, bad_out is the function with the chosen net forced to its stuck value; with a stuck at 0, vector 3'b110 gives good_out 1, bad_out 0 and detect 1.
- R5: A vector whose side input holds its controlling value (b=0 at the AND, or c=1 at the OR) masks a fault on a or b, and detect stays 0.
- R6: The vector store holds 8 entries, written at vec_addr on vec_wr; a count write above 8 is stored as 8.
- R7: A sweep clears det_map at start, then sets bit i when any of the first count stored vectors makes the fault with code i visible; a set bit stays set for the rest of the sweep.
- R8: coverage equals the number of set bits in det_map.
- R9: Faults form the outer loop and vectors the inner loop, one pair per cycle, so done pulses for one cycle exactly 10*count clock edges after the edge that samples start; busy is high in between, and with a count of 0 done follows the start edge directly.
- R10: After reset det_map and coverage are 0, busy and done are low, and the fault register holds the no-fault code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_wr | input | 1 | Write strobe for the vector store |
| vec_addr | input | 3 | Vector store entry to write |
| vec_data | input | 3 | Vector to write (a,b,c in bits 2,1,0) |
| cnt_wr | input | 1 | Write strobe for the valid vector count |
| cnt_data | input | 4 | Valid vector count, saturated at 8 |
| fsel_wr | input | 1 | Write strobe for the fault code register |
| fsel_data | input | 4 | Fault code to write |
| probe_vec | input | 3 | Vector applied to both copies when idle |
| start | input | 1 | Begins a sweep when idle |
| good_out | output | 1 | Output of the fault-free copy |
| bad_out | output | 1 | Output of the faulty copy |
| detect | output | 1 | Mismatch between the two copies |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse at the end of a sweep |
| det_map | output | 10 | Per-fault detected bitmap, bit index = fault code |
| coverage | output | 4 | Number of detected faults |

## Verification
The bench applies every vector to every one of the sixteen fault codes by hand and compares against a separate evaluation of the function. A wrong net decode or a swapped stuck value would then change bad_out on some row, and a broken no-fault range would show a mismatch with the reference. Sweeps run over several vector sets: the full set, a single vector, a masking-only set, an empty set, and a set loaded with an oversized count. A sequencer that dropped the last vector or the last fault would miss bits in det_map. A map that was not cleared would keep bits from an earlier sweep. A count that was not saturated would shift the arrival of done, because that arrival is checked to the exact clock edge.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int unsigned NET_CNT   = 5;
  localparam int unsigned FAULT_CNT = 2 * NET_CNT;
  localparam int unsigned CODE_W    = 4;
  localparam int unsigned VEC_W     = 3;

  typedef logic [CODE_W-1:0] fcode_t;
  typedef logic [VEC_W-1:0]  tvec_t;

  localparam fcode_t IDLE_CODE = 4'hF;

  typedef enum logic [2:0] {
    NET_A   = 3'd0,
    NET_B   = 3'd1,
    NET_C   = 3'd2,
    NET_AND = 3'd3,
    NET_Y   = 3'd4
  } net_id_t;
endpackage

// File: rtl/fault_copy.sv
module fault_copy
  import sa_pkg::*;
(
  input  tvec_t  vec,
  input  fcode_t code,
  output logic   y
);
  logic       hit;
  logic [2:0] net;
  logic       sv;
  logic       na, nb, nc, nand_raw, nand_f, y_raw;

  always_comb begin
    hit      = (code < fcode_t'(FAULT_CNT));
    net      = code[CODE_W-1:1];
    sv       = code[0];
    na       = (hit && net == NET_A)   ? sv : vec[2];
    nb       = (hit && net == NET_B)   ? sv : vec[1];
    nc       = (hit && net == NET_C)   ? sv : vec[0];
    nand_raw = na & nb;
    nand_f   = (hit && net == NET_AND) ? sv : nand_raw;
    y_raw    = nand_f | nc;
    y        = (hit && net == NET_Y)   ? sv : y_raw;
  end
endmodule

// File: rtl/vec_store.sv
module vec_store
  import sa_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  tvec_t         wr_data,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_data,
  input  logic [AW-1:0] rd_addr,
  output tvec_t         rd_data,
  output logic [CW-1:0] count
);
  tvec_t         mem_q [DEPTH];
  tvec_t         mem_d [DEPTH];
  logic [CW-1:0] cnt_d;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      mem_d[i] = mem_q[i];
      if (wr_en && wr_addr == AW'(i)) mem_d[i] = wr_data;
    end
    cnt_d = count;
    if (cnt_wr) cnt_d = (cnt_data > CW'(DEPTH)) ? CW'(DEPTH) : cnt_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      count <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
      count <= cnt_d;
    end
  end

  assign rd_data = mem_q[rd_addr];

  // R6
  cnt_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

// File: rtl/sweep_seq.sv
module sweep_seq
  import sa_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [CW-1:0]        count,
  input  logic                 detect,
  output logic                 busy,
  output logic                 done,
  output fcode_t               fidx,
  output logic [AW-1:0]        vidx,
  output logic [FAULT_CNT-1:0] det_map
);
  logic                 busy_d, done_d;
  fcode_t               fidx_d;
  logic [AW-1:0]        vidx_d;
  logic [FAULT_CNT-1:0] map_d;
  logic                 last_vec, last_fault;

  always_comb begin
    last_vec   = ((CW'(vidx) + CW'(1)) == count);
    last_fault = (fidx == fcode_t'(FAULT_CNT - 1));
    busy_d = busy;
    done_d = 1'b0;
    fidx_d = fidx;
    vidx_d = vidx;
    map_d  = det_map;
    if (!busy) begin
      if (start) begin
        map_d  = '0;
        fidx_d = '0;
        vidx_d = '0;
        if (count == '0) done_d = 1'b1;
        else             busy_d = 1'b1;
      end
    end else begin
      if (detect) map_d[fidx] = 1'b1;
      if (last_vec) begin
        vidx_d = '0;
        if (last_fault) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          fidx_d = fidx + fcode_t'(1);
        end
      end else begin
        vidx_d = vidx + AW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      fidx    <= '0;
      vidx    <= '0;
      det_map <= '0;
    end else begin
      busy    <= busy_d;
      done    <= done_d;
      fidx    <= fidx_d;
      vidx    <= vidx_d;
      det_map <= map_d;
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R7
  map_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((det_map & $past(det_map)) == $past(det_map)));
  // R9
  fidx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (fidx < fcode_t'(FAULT_CNT)));
endmodule

// File: rtl/fault_miter.sv
module fault_miter
  import sa_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW  = $clog2(DEPTH),
  localparam int unsigned CW  = $clog2(DEPTH + 1),
  localparam int unsigned CVW = $clog2(FAULT_CNT + 1)
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vec_wr,
  input  logic [AW-1:0]        vec_addr,
  input  logic [VEC_W-1:0]     vec_data,
  input  logic                 cnt_wr,
  input  logic [CW-1:0]        cnt_data,
  input  logic                 fsel_wr,
  input  logic [CODE_W-1:0]    fsel_data,
  input  logic [VEC_W-1:0]     probe_vec,
  input  logic                 start,
  output logic                 good_out,
  output logic                 bad_out,
  output logic                 detect,
  output logic                 busy,
  output logic                 done,
  output logic [FAULT_CNT-1:0] det_map,
  output logic [CVW-1:0]       coverage
);
  logic [1:0]    rst_sync;
  logic          srst_n;
  fcode_t        fsel_q, fsel_d;
  fcode_t        seq_fidx, cur_code;
  logic [AW-1:0] seq_vidx;
  tvec_t         st_vec, cur_vec;
  logic [CW-1:0] vcount;
  logic [1:0]    copy_y;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  always_comb begin
    fsel_d = fsel_wr ? fsel_data : fsel_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) fsel_q <= IDLE_CODE;
    else         fsel_q <= fsel_d;
  end

  vec_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (srst_n),
    .wr_en    (vec_wr),
    .wr_addr  (vec_addr),
    .wr_data  (vec_data),
    .cnt_wr   (cnt_wr),
    .cnt_data (cnt_data),
    .rd_addr  (seq_vidx),
    .rd_data  (st_vec),
    .count    (vcount)
  );

  always_comb begin
    cur_code = busy ? seq_fidx : fsel_q;
    cur_vec  = busy ? st_vec   : probe_vec;
  end

  // copy 0 is the fault-free reference, copy 1 takes the selected fault
  for (genvar g = 0; g < 2; g++) begin : g_copy
    fault_copy u_copy (
      .vec  (cur_vec),
      .code ((g == 0) ? IDLE_CODE : cur_code),
      .y    (copy_y[g])
    );
  end

  assign good_out = copy_y[0];
  assign bad_out  = copy_y[1];
  assign detect   = copy_y[0] ^ copy_y[1];

  sweep_seq #(.DEPTH(DEPTH)) u_seq (
    .clk     (clk),
    .rst_n   (srst_n),
    .start   (start),
    .count   (vcount),
    .detect  (detect),
    .busy    (busy),
    .done    (done),
    .fidx    (seq_fidx),
    .vidx    (seq_vidx),
    .det_map (det_map)
  );

  always_comb begin
    coverage = '0;
    for (int i = 0; i < FAULT_CNT; i++) coverage = coverage + CVW'(det_map[i]);
  end

  // R1
  nofault_match_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!busy && fsel_q >= fcode_t'(FAULT_CNT)) |-> !detect);
  // R8
  cov_range_chk: assert property (@(posedge clk) disable iff (!srst_n)
    coverage <= CVW'(FAULT_CNT));
  // R7
  map_clear_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!busy && start && vcount != '0) |=> (det_map == '0));
endmodule

// File: tb/sim_fault_miter.sv
module sim_fault_miter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vec_wr = 1'b0;
  logic [2:0] vec_addr = '0;
  logic [2:0] vec_data = '0;
  logic       cnt_wr = 1'b0;
  logic [3:0] cnt_data = '0;
  logic       fsel_wr = 1'b0;
  logic [3:0] fsel_data = '0;
  logic [2:0] probe_vec = '0;
  logic       start = 1'b0;
  logic       good_out, bad_out, detect, busy, done;
  logic [9:0] det_map;
  logic [3:0] coverage;

  int n_chk = 0;
  int n_fail = 0;
  logic [2:0] set_v [8];
  int         set_n;

  always #10 clk = ~clk;

  fault_miter u0 (
    .clk(clk), .rst_n(rst_n), .vec_wr(vec_wr), .vec_addr(vec_addr),
    .vec_data(vec_data), .cnt_wr(cnt_wr), .cnt_data(cnt_data),
    .fsel_wr(fsel_wr), .fsel_data(fsel_data), .probe_vec(probe_vec),
    .start(start), .good_out(good_out), .bad_out(bad_out), .detect(detect),
    .busy(busy), .done(done), .det_map(det_map), .coverage(coverage)
  );

  function automatic logic ref_y(input logic [2:0] v, input int code);
    logic a, b, c, n, y;
    int   net;
    logic sv;
    net = code / 2;
    sv  = logic'(code % 2);
    if (code >= 10) net = 99;
    a = (net == 0) ? sv : v[2];
    b = (net == 1) ? sv : v[1];
    c = (net == 2) ? sv : v[0];
    n = (net == 3) ? sv : (a & b);
    y = (net == 4) ? sv : (n | c);
    return y;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_fault(input int code);
    @(negedge clk);
    fsel_wr = 1'b1; fsel_data = 4'(code);
    @(negedge clk);
    fsel_wr = 1'b0;
  endtask

  task automatic load_set(input int cnt_write);
    for (int i = 0; i < set_n; i++) begin
      @(negedge clk);
      vec_wr = 1'b1; vec_addr = 3'(i); vec_data = set_v[i];
    end
    @(negedge clk);
    vec_wr = 1'b0;
    cnt_wr = 1'b1; cnt_data = 4'(cnt_write);
    @(negedge clk);
    cnt_wr = 1'b0;
  endtask

  task automatic run_sweep(input string tag, input int used);
    logic [9:0] exp_map;
    int exp_cov, edges;
    exp_map = '0;
    for (int f = 0; f < 10; f++)
      for (int i = 0; i < used; i++)
        if (ref_y(set_v[i], 10) != ref_y(set_v[i], f)) exp_map[f] = 1'b1;
    exp_cov = $countones(exp_map);
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    edges = 0;
    while (!done && edges < 200) begin
      @(posedge clk); edges++;
      @(negedge clk);
    end
    // R9: arrival edge of done
    check({tag, " R9 done edge"}, edges, 10 * used);
    // R7
    check({tag, " R7 det_map"}, int'(det_map), int'(exp_map));
    // R8
    check({tag, " R8 coverage"}, int'(coverage), exp_cov);
    @(posedge clk);
    @(negedge clk);
    // R9: pulse is one cycle
    check({tag, " R9 done low"}, int'(done), 0);
    check({tag, " R9 busy low"}, int'(busy), 0);
  endtask

  initial begin
    repeat (500000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10
    check("R10 det_map", int'(det_map), 0);
    check("R10 coverage", int'(coverage), 0);
    check("R10 busy", int'(busy), 0);
    check("R10 done", int'(done), 0);
    probe_vec = 3'b110;
    #1;
    check("R10 fault reg idle", int'(detect), 0);

    // R1 R2 R3 R4: every code against every vector
    for (int code = 0; code < 16; code++) begin
      set_fault(code);
      for (int v = 0; v < 8; v++) begin
        probe_vec = 3'(v);
        #1;
        check("R2 good_out", int'(good_out), int'(ref_y(3'(v), 10)));
        if (code >= 10) check("R1 no fault", int'(bad_out), int'(good_out));
        else check("R4 bad_out", int'(bad_out), int'(ref_y(3'(v), code)));
        check("R3 detect", int'(detect),
              int'(ref_y(3'(v), 10) ^ ref_y(3'(v), code)));
      end
    end

    // R4: a stuck at 0 with 110
    set_fault(0);
    probe_vec = 3'b110;
    #1;
    check("R4 a s0 good", int'(good_out), 1);
    check("R4 a s0 bad", int'(bad_out), 0);
    check("R4 a s0 detect", int'(detect), 1);
    // R5: masking by b=0 and by c=1
    probe_vec = 3'b100;
    #1;
    check("R5 mask b=0", int'(detect), 0);
    probe_vec = 3'b111;
    #1;
    check("R5 mask c=1", int'(detect), 0);
    set_fault(2);
    probe_vec = 3'b011;
    #1;
    check("R5 b s0 mask c=1", int'(detect), 0);
    set_fault(10);

    // R7 R8 R9: full vector set
    for (int i = 0; i < 8; i++) set_v[i] = 3'(i);
    set_n = 8;
    load_set(8);
    run_sweep("full", 8);
    // single vector
    set_v[0] = 3'b110; set_n = 1;
    load_set(1);
    run_sweep("single", 1);
    // masking-only set
    set_v[0] = 3'b101; set_v[1] = 3'b111; set_v[2] = 3'b001; set_n = 3;
    load_set(3);
    run_sweep("masked", 3);
    // mixed set, clears old bits
    set_v[0] = 3'b000; set_v[1] = 3'b011; set_n = 2;
    load_set(2);
    run_sweep("mixed", 2);
    // empty set
    set_n = 0;
    load_set(0);
    run_sweep("empty", 0);
    // R6: oversized count saturates to 8
    for (int i = 0; i < 8; i++) set_v[i] = 3'(7 - i);
    set_n = 8;
    load_set(15);
    run_sweep("R6 sat", 8);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule